// File: doc/BRIEF.md
# Receive FIFO with Watermark Flow Control

This block buffers received line-side frame data for one port, one 64-bit (8-byte) word per entry. A frame is written word by word, with start and end markers. Its words become visible to the reader only once the end word has been stored. The reader takes committed words in arrival order. Read data comes from a registered memory port, so it appears one cycle after the request.

The fill level is the number of committed entries. It is compared with two programmable watermarks, both counted in 8-byte entries. A flow-control request is raised once the level reaches the high mark. It is held until the level drops below the low mark. This hysteresis keeps the request from toggling while the level hovers near one threshold. A typical setting is a low mark of 114 entries (912 bytes) with a high mark above it.

A frame that cannot be stored is discarded as a whole and counted once. This happens when the buffer fills partway through the frame, or when the port is held in soft reset. The drop count saturates and clears when it is read.

Top module: `rx_wm_fifo`

## Requirements
- R1: After `rst`, `fill` is 0, `fc_req` is 0, `rd_valid` is 0 and `drop_cnt` is 0. `fill` counts committed 64-bit entries and never exceeds 2^ADDR_W.
- R2: Words of a frame do not raise `fill` until the word with `wr_eof` set is accepted. In that same edge, `fill` rises by the frame length.
- R3: When `fill` is at least `hi_wm` (and `lo_wm` < `hi_wm`), `fc_req` is 1 from the following clock edge on.
- R4: Once raised, `fc_req` holds while `fill` is at least `lo_wm`. It returns to 0 one edge after `fill` falls below `lo_wm`.
- R5: A frame word that would push the stored words (committed plus in-progress) past 2^ADDR_W discards the whole frame. The write pointer rolls back, `drop_cnt` rises by exactly 1, and later words of that frame up to `wr_eof` are ignored.
- R6: While `soft_rst` is 1, the buffer is emptied. `fill` and `fc_req` are 0 after the next edge. A frame in progress when `soft_rst` rises counts as one drop. Each frame started (`wr_sof`) while `soft_rst` is 1 counts as one drop.
- R7: `drop_cnt` saturates at 2^CNT_W-1 and does not wrap.
- R8: In a cycle with `drop_rd` at 1, `drop_cnt` shows the value being read. At the next edge it becomes 0, or 1 if a drop occurs in that same cycle.
- R9: `rd_en` while `fill` is 0 has no effect: `rd_valid` stays 0 and `fill` stays 0.
- R10: `soft_rst` does not clear `drop_cnt`.
- R11: For each accepted `rd_en`, `rd_valid` is 1 one edge later, with `rd_data` carrying the oldest unread committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Port soft reset, active high |
| wr_en | input | 1 | Write word strobe |
| wr_sof | input | 1 | Word is the first of a frame |
| wr_eof | input | 1 | Word is the last of a frame |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | `rd_data` valid |
| fill | output | ADDR_W+1 | Committed entries |
| hi_wm | input | WM_W | High watermark in entries |
| lo_wm | input | WM_W | Low watermark in entries |
| fc_req | output | 1 | Flow-control request |
| drop_rd | input | 1 | Drop counter read strobe |
| drop_cnt | output | CNT_W | Dropped-frame count |

## Verification
A drop and a counter read can fall in the same cycle. They interact because the read clears the count while the drop tries to increment it. The bench provokes this by holding `soft_rst` high while it sends a single-word frame and pulses `drop_rd` in the same cycle. It then checks that `drop_cnt` shows the old count during that cycle and 1 after the edge. The other cases around it are also checked: a read with no drop clears the count to 0, and drops against a full count leave it saturated.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    WS_IDLE    = 2'd0,
    WS_FRAME   = 2'd1,
    WS_DISCARD = 2'd2
  } wr_state_t;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W:0]   rd_ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W:0]   commit_ptr,
  output logic              drop_pulse
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(1 << ADDR_W);

  wr_state_t st_q, st_n;
  logic [PW-1:0] wp_q, wp_n, cp_q, cp_n, base;

  always_comb begin
    st_n       = st_q;
    wp_n       = wp_q;
    cp_n       = cp_q;
    mem_we     = 1'b0;
    drop_pulse = 1'b0;
    base       = wr_sof ? cp_q : wp_q;
    if (soft_rst) begin
      wp_n = '0;
      cp_n = '0;
      if (st_q == WS_FRAME) begin
        drop_pulse = 1'b1;
        st_n = (wr_en && wr_eof) ? WS_IDLE : WS_DISCARD;
      end else if (wr_en && wr_sof) begin
        drop_pulse = 1'b1;
        st_n = wr_eof ? WS_IDLE : WS_DISCARD;
      end else if (wr_en && wr_eof && st_q == WS_DISCARD) begin
        st_n = WS_IDLE;
      end
    end else if (wr_en) begin
      if (wr_sof || st_q == WS_FRAME) begin
        if (base - rd_ptr == FULL_CNT) begin
          drop_pulse = 1'b1;
          wp_n = cp_q;
          st_n = wr_eof ? WS_IDLE : WS_DISCARD;
        end else begin
          mem_we = 1'b1;
          wp_n   = base + 1'b1;
          if (wr_eof) begin
            cp_n = base + 1'b1;
            st_n = WS_IDLE;
          end else begin
            st_n = WS_FRAME;
          end
        end
      end else if (st_q == WS_DISCARD && wr_eof) begin
        st_n = WS_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= WS_IDLE;
      wp_q <= '0;
      cp_q <= '0;
    end else begin
      st_q <= st_n;
      wp_q <= wp_n;
      cp_q <= cp_n;
    end
  end

  assign mem_waddr  = base[ADDR_W-1:0];
  assign mem_wdata  = wr_data;
  assign commit_ptr = cp_q;

  // speculative words never exceed capacity
  p_spec_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (wp_q - rd_ptr) <= FULL_CNT);
  // a frame that hits full rolls the write pointer back to the commit point
  p_rollback_r5: assert property (@(posedge clk) disable iff (rst)
    (drop_pulse && !soft_rst) |=> (wp_q == cp_q));
endmodule

// File: rtl/rxf_flow.sv
module rxf_flow #(
  parameter int PW   = 10,
  parameter int WM_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_rst,
  input  logic [PW-1:0]   level,
  input  logic [WM_W-1:0] hi_wm,
  input  logic [WM_W-1:0] lo_wm,
  output logic            fc_req
);
  logic [WM_W-1:0] lvl_x;
  assign lvl_x = WM_W'(level);

  always_ff @(posedge clk) begin
    if (rst || soft_rst)   fc_req <= 1'b0;
    else if (lvl_x >= hi_wm) fc_req <= 1'b1;
    else if (lvl_x < lo_wm)  fc_req <= 1'b0;
  end

  p_fc_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && lo_wm < hi_wm && lvl_x >= hi_wm) |=> fc_req);
  p_fc_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && lvl_x < lo_wm) |=> !fc_req);
  p_fc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && lvl_x >= lo_wm && lvl_x < hi_wm) |=> $stable(fc_req));
endmodule

// File: rtl/rxf_drop_cnt.sv
module rxf_drop_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drop,
  input  logic             rd,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (rd)                  cnt <= drop ? CNT_W'(1) : '0;
    else if (drop && cnt != CMAX) cnt <= cnt + 1'b1;
  end

  p_sat_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && !rd) |=> (cnt == CMAX));
  p_clr_r8: assert property (@(posedge clk) disable iff (rst)
    rd |=> (cnt <= CNT_W'(1)));
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!rd && !drop) |=> $stable(cnt));
endmodule

// File: rtl/rx_wm_fifo.sv
module rx_wm_fifo #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 9,
  parameter int WM_W   = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W:0]   fill,
  input  logic [WM_W-1:0]   hi_wm,
  input  logic [WM_W-1:0]   lo_wm,
  output logic              fc_req,
  input  logic              drop_rd,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(1 << ADDR_W);

  logic [PW-1:0]     rd_ptr, cm_ptr, level;
  logic              mem_we, rd_fire, drop_pulse;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  assign level   = cm_ptr - rd_ptr;
  assign rd_fire = rd_en && !soft_rst && (level != '0);
  assign fill    = level;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) rd_ptr <= '0;
    else if (rd_fire)    rd_ptr <= rd_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_fire;
  end

  rxf_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk, .rst, .soft_rst, .wr_en, .wr_sof, .wr_eof, .wr_data,
    .rd_ptr, .mem_we, .mem_waddr, .mem_wdata,
    .commit_ptr(cm_ptr), .drop_pulse
  );

  rxf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk, .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(rd_fire), .raddr(rd_ptr[ADDR_W-1:0]), .rdata(rd_data)
  );

  rxf_flow #(.PW(PW), .WM_W(WM_W)) u_flow (
    .clk, .rst, .soft_rst, .level, .hi_wm, .lo_wm, .fc_req
  );

  rxf_drop_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst, .drop(drop_pulse), .rd(drop_rd), .cnt(drop_cnt)
  );

  p_fill_bound_r1: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL_CNT);
  p_srst_r6: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (fill == '0 && !fc_req));
  p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fill == '0) |=> !rd_valid);
  p_rd_valid_r11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

// File: tb/tb_rx_wm_fifo.sv
module tb_rx_wm_fifo;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 9;
  localparam int WM_W   = 12;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst = 1'b0, wr_en = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rd_en = 1'b0, drop_rd = 1'b0;
  logic [WM_W-1:0] hi_wm = 12'd200, lo_wm = 12'd114;
  logic [DATA_W-1:0] rd_data;
  logic rd_valid, fc_req;
  logic [ADDR_W:0] fill;
  logic [CNT_W-1:0] drop_cnt;

  int n_chk = 0, n_fail = 0;
  int seq = 0;
  bit done = 0;
  logic [DATA_W-1:0] sb [$];

  always #5 clk = ~clk;

  rx_wm_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WM_W(WM_W), .CNT_W(CNT_W)) dut (
    .clk, .rst, .soft_rst, .wr_en, .wr_sof, .wr_eof, .wr_data,
    .rd_en, .rd_data, .rd_valid, .fill, .hi_wm, .lo_wm, .fc_req,
    .drop_rd, .drop_cnt
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // driver: pushes the words of a frame into the scoreboard once it commits
  task automatic send_frame(input int len, input bit commits);
    logic [DATA_W-1:0] words [$];
    for (int i = 0; i < len; i++) begin
      wr_data = {32'hA5C3_0000, 32'(seq)};
      seq++;
      words.push_back(wr_data);
      wr_en = 1'b1; wr_sof = (i == 0); wr_eof = (i == len - 1);
      tick;
    end
    wr_en = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
    if (commits) foreach (words[k]) sb.push_back(words[k]);
  endtask

  task automatic read_n(input int n);
    rd_en = 1'b1;
    repeat (n) tick;
    rd_en = 1'b0;
  endtask

  // monitor: compares every delivered word with the scoreboard (R11, R2)
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb.size() == 0) check(1'b0, "R11 unexpected word", longint'(rd_data[31:0]), -1);
      else begin
        logic [DATA_W-1:0] e;
        e = sb.pop_front();
        check(rd_data == e, "R11 read order", longint'(rd_data[31:0]), longint'(e[31:0]));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1 watchdog expired", 0, 1);
    finish_run;
  end

  initial begin
    repeat (3) tick;
    rst = 1'b0;
    tick;
    // R1 reset state
    check(fill == 0, "R1 fill after reset", fill, 0);
    check(fc_req == 0, "R1 fc_req after reset", fc_req, 0);
    check(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);
    check(drop_cnt == 0, "R1 drop_cnt after reset", drop_cnt, 0);

    // R2 commit only at end of frame
    wr_data = 64'h11; wr_en = 1; wr_sof = 1; tick;
    wr_sof = 0; wr_data = 64'h12; tick;
    wr_en = 0;
    check(fill == 0, "R2 partial frame invisible", fill, 0);
    sb.push_back(64'h11); sb.push_back(64'h12); sb.push_back(64'h13);
    wr_data = 64'h13; wr_en = 1; wr_eof = 1; tick;
    wr_en = 0; wr_eof = 0;
    check(fill == 3, "R2 fill after end word", fill, 3);
    read_n(3); tick;
    check(fill == 0, "R11 drained", fill, 0);

    // R9 read while empty
    rd_en = 1; tick; rd_en = 0;
    check(rd_valid == 0, "R9 no valid on empty read", rd_valid, 0);
    check(fill == 0, "R9 fill unchanged", fill, 0);

    // R3 / R4 hysteresis, hi=200 lo=114
    for (int f = 0; f < 19; f++) send_frame(10, 1);
    tick;
    check(fc_req == 0, "R3 below high mark", fc_req, 0);
    send_frame(10, 1);
    check(fill == 200, "R3 fill at high mark", fill, 200);
    check(fc_req == 0, "R3 request is registered", fc_req, 0);
    tick;
    check(fc_req == 1, "R3 request after reaching high", fc_req, 1);
    read_n(86); tick;
    check(fill == 114, "R4 fill at low mark", fill, 114);
    check(fc_req == 1, "R4 held at low mark", fc_req, 1);
    read_n(1);
    check(fc_req == 1, "R4 one edge latency", fc_req, 1);
    tick;
    check(fc_req == 0, "R4 released below low", fc_req, 0);
    read_n(113); tick;
    check(fill == 0, "R4 drained", fill, 0);

    // R5 overflow mid-frame
    for (int f = 0; f < 51; f++) send_frame(10, 1);
    check(fill == 510, "R5 fill before overflow", fill, 510);
    send_frame(4, 0);
    check(fill == 510, "R5 fill after dropped frame", fill, 510);
    check(drop_cnt == 1, "R5 counted once", drop_cnt, 1);
    read_n(20); tick;
    send_frame(2, 1);
    check(fill == 492, "R5 next frame accepted", fill, 492);
    read_n(492); tick;
    check(fill == 0, "R5 drained", fill, 0);

    // R8 read without drop
    drop_rd = 1;
    check(drop_cnt == 1, "R8 value during read", drop_cnt, 1);
    tick; drop_rd = 0;
    check(drop_cnt == 0, "R8 cleared", drop_cnt, 0);

    // R6 / R10 soft reset
    send_frame(5, 1);
    wr_data = 64'h77; wr_en = 1; wr_sof = 1; tick;
    wr_sof = 0; tick; wr_en = 0;
    soft_rst = 1; tick;
    check(fill == 0, "R6 emptied", fill, 0);
    check(fc_req == 0, "R6 fc_req low", fc_req, 0);
    check(drop_cnt == 1, "R6 partial frame counted", drop_cnt, 1);
    for (int i = 0; i < 3; i++) begin
      wr_en = 1; wr_sof = 1; wr_eof = 1; tick;
    end
    wr_en = 0; wr_sof = 0; wr_eof = 0;
    check(drop_cnt == 4, "R6 frames during reset counted", drop_cnt, 4);
    sb.delete();
    soft_rst = 0; tick;
    check(drop_cnt == 4, "R10 count survives soft reset", drop_cnt, 4);
    send_frame(2, 1);
    check(fill == 2, "R6 works after release", fill, 2);
    read_n(2); tick;

    // R8 drop and read in the same cycle
    soft_rst = 1; wr_en = 1; wr_sof = 1; wr_eof = 1; drop_rd = 1;
    #1;
    check(drop_cnt == 4, "R8 old value on simultaneous read", drop_cnt, 4);
    tick;
    wr_en = 0; wr_sof = 0; wr_eof = 0; drop_rd = 0;
    check(drop_cnt == 1, "R8 drop kept after clear", drop_cnt, 1);

    // R7 saturation
    wr_en = 1; wr_sof = 1; wr_eof = 1;
    repeat (260) tick;
    wr_en = 0; wr_sof = 0; wr_eof = 0;
    check(drop_cnt == 255, "R7 saturated", drop_cnt, 255);
    wr_en = 1; wr_sof = 1; wr_eof = 1; tick;
    wr_en = 0; wr_sof = 0; wr_eof = 0;
    check(drop_cnt == 255, "R7 stays saturated", drop_cnt, 255);
    soft_rst = 0;
    drop_rd = 1; tick; drop_rd = 0;
    check(drop_cnt == 0, "R8 clear from saturation", drop_cnt, 0);

    repeat (3) tick;
    check(sb.size() == 0, "R11 scoreboard empty", sb.size(), 0);
    finish_run;
  end
endmodule